// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block puts the state register of a small synchronous circuit into multiplexed scan cells and runs a full manufacturing-style scan test on it without outside help. Each scan cell picks either its functional next-state input or the serial input from its chain neighbour. One test-control line makes that choice for every cell. The cells form several chains of equal length, and each chain has its own serial input and serial output.

After a start pulse the sequencer first runs a chain integrity flush. It then works through a small internal store of test vectors. For each vector it shifts the state in, applies one functional capture clock with the vector's primary inputs, and shifts the captured response out while the next vector shifts in. Every bit that leaves a chain, and every primary output at capture, is compared with the stored expectation. Bits marked don't-care are not compared. The total cycle count is exact, and a done flag and a mismatch count report the result.

Top module: `scan_test_seq`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in idle with `test_ctrl`=0, `done`=0 and `mismatch_cnt`=0, including when it is applied in the middle of a run. In idle `test_ctrl` stays 0.
- R2: The cycle after `start` is sampled in idle or done, the flush begins. `test_ctrl`=1 for CHAIN_LEN+4 clocks, and at flush shift k (from 0) every chain receives bit 1 of k (pattern 0,0,1,1,...). The scan output of each chain shows pattern bit k-CHAIN_LEN at flush shift k ≥ CHAIN_LEN, and pattern bits 4, 5, ... at the shifts of the first load.
- R3: During a load, the bit shifted in at shift j (0..CHAIN_LEN-1) ends at chain position CHAIN_LEN-1-j. Position CHAIN_LEN-1 drives the scan output. Cell (chain c, position p) has flat index f = c·CHAIN_LEN + p. Stimulus bit f of vector v is 0 for v=0, 1 for v=1, and otherwise ((3f+5v) mod 7) < 3.
- R4: After every load comes exactly one clock with `test_ctrl`=0. During that clock primary input j carries ((v+j) mod 3)==0. Outside capture, the primary inputs are 0.
- R5: The circuit under test computes next[f] = s[(f+1) mod NFF] xor (s[f] and pi[f mod NPI]) and po[j] = s[j] xor pi[j mod NPI], where NFF = NCHAIN·CHAIN_LEN.
- R6: The response captured for vector v leaves during the next load, or during the final unload for the last vector. Chain c shows response bit c·CHAIN_LEN+CHAIN_LEN-1-j at shift j.
- R7: A run lasts exactly (NVEC+2)·CHAIN_LEN + NVEC + 4 clocks. `done` rises after the last of them and stays high, with `test_ctrl`=0, until the next start.
- R8: During the final unload, zeros are shifted in. While `done` is high, every scan output reads 0.
- R9: `mismatch_cnt` counts every compared scan-output bit and primary-output bit that differs from its expectation. Response bit f of vector v is don't-care when (f+v) mod 4 == 3 and is never compared. On a fault-free circuit the count ends at 0, even though the stored expectation for don't-care bits is the complement of the real response.
- R10: All chains share the single test-control line and shift in lockstep. Every chain's scan output follows R2 and R6 at the same clocks.
- R11: A new start from done clears the count and repeats the identical sequence. A start pulse during a run has no effect on its length or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sequencer and scan cells |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run when idle or done |
| test_ctrl | output | 1 | 1 = serial scan input selected, 0 = functional input |
| scan_out | output | NCHAIN | Serial output of each chain |
| prim_out | output | NPO | Primary outputs of the circuit under test |
| done | output | 1 | Run finished; held until next start |
| mismatch_cnt | output | MISM_W | Number of compared bits that disagreed |

## Verification
The embedded properties check on every cycle that a capture lasts exactly one clock, that the flush ends only after its full length, that the mismatch count never drops during a run, that each chain's first cell takes the serial input whenever test control is high, and that all scan outputs sit at zero while done is high. Only the bench scenarios can show the exact bit streams at every scan output. Those streams are the flush pattern, the placement of stimulus and response, the capture-time primary outputs and the exact total run length. The bench also covers the effect of a mid-run reset, the effect of a start pulse during a run, and a restart from done.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FLUSH,
      SQ_LOAD,
      SQ_CAPT,
      SQ_UNLOAD,
      SQ_DONE
   } sq_state_e;

   // flush pattern 0,0,1,1 repeating
   function automatic logic flush_bit(int k);
      return ((k / 2) % 2) == 1;
   endfunction

   function automatic logic stim_bit(int v, int f);
      if (v == 0) return 1'b0;
      if (v == 1) return 1'b1;
      return ((3 * f + 5 * v) % 7) < 3;
   endfunction

   function automatic logic pin_bit(int v, int j);
      return ((v + j) % 3) == 0;
   endfunction

   function automatic logic resp_bit(int v, int f, int nff, int npi);
      return stim_bit(v, (f + 1) % nff) ^ (stim_bit(v, f) & pin_bit(v, f % npi));
   endfunction

   function automatic logic pout_bit(int v, int j, int npi);
      return stim_bit(v, j) ^ pin_bit(v, j % npi);
   endfunction

   function automatic logic dc_bit(int v, int f);
      return ((f + v) % 4) == 3;
   endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic tc,
   input  logic d,
   input  logic sd,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= tc ? sd : d;
   end
endmodule

// File: rtl/scan_cut.sv
module scan_cut #(
   parameter int NCHAIN    = 2,
   parameter int CHAIN_LEN = 4,
   parameter int NPI       = 2,
   parameter int NPO       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tc,
   input  logic [NCHAIN-1:0] si,
   input  logic [NPI-1:0]    pi,
   output logic [NCHAIN-1:0] so,
   output logic [NPO-1:0]    po
);
   localparam int NFF = NCHAIN * CHAIN_LEN;

   logic [NFF-1:0] st;
   logic [NFF-1:0] ns;
   logic [NFF-1:0] rot;
   logic [NFF-1:0] pi_rep;

   assign rot = {st[0], st[NFF-1:1]};

   for (genvar f = 0; f < NFF; f++) begin : g_pirep
      assign pi_rep[f] = pi[f % NPI];
   end

   assign ns = rot ^ (st & pi_rep);

   for (genvar j = 0; j < NPO; j++) begin : g_po
      assign po[j] = st[j] ^ pi[j % NPI];
   end

   for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
      for (genvar p = 0; p < CHAIN_LEN; p++) begin : g_cell
         logic sd_w;
         if (p == 0) begin : g_head
            assign sd_w = si[c];
         end else begin : g_body
            assign sd_w = st[c*CHAIN_LEN + p - 1];
         end
         scan_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .tc    (tc),
            .d     (ns[c*CHAIN_LEN + p]),
            .sd    (sd_w),
            .q     (st[c*CHAIN_LEN + p])
         );
      end
      assign so[c] = st[c*CHAIN_LEN + CHAIN_LEN - 1];

      assert_shift_entry_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         tc |=> (st[c*CHAIN_LEN] == $past(si[c])));
   end
endmodule

// File: rtl/scan_vec_rom.sv
module scan_vec_rom
   import scan_seq_pkg::*;
#(
   parameter int NVEC = 5,
   parameter int NFF  = 8,
   parameter int NPI  = 2,
   parameter int NPO  = 2
) (
   output logic [NVEC*NFF-1:0] stim_flat,
   output logic [NVEC*NFF-1:0] exp_flat,
   output logic [NVEC*NFF-1:0] dc_flat,
   output logic [NVEC*NPI-1:0] pi_flat,
   output logic [NVEC*NPO-1:0] po_flat
);
   for (genvar v = 0; v < NVEC; v++) begin : g_vec
      for (genvar f = 0; f < NFF; f++) begin : g_ff
         assign stim_flat[v*NFF + f] = stim_bit(v, f);
         assign dc_flat[v*NFF + f]   = dc_bit(v, f);
         // don't-care positions hold the complement on purpose
         assign exp_flat[v*NFF + f]  = resp_bit(v, f, NFF, NPI) ^ dc_bit(v, f);
      end
      for (genvar j = 0; j < NPI; j++) begin : g_pi
         assign pi_flat[v*NPI + j] = pin_bit(v, j);
      end
      for (genvar j = 0; j < NPO; j++) begin : g_po
         assign po_flat[v*NPO + j] = pout_bit(v, j, NPI);
      end
   end
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
   import scan_seq_pkg::*;
#(
   parameter int NCHAIN    = 2,
   parameter int CHAIN_LEN = 4,
   parameter int NVEC      = 5,
   parameter int NPI       = 2,
   parameter int NPO       = 2,
   parameter int MISM_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NCHAIN-1:0]             so,
   input  logic [NPO-1:0]                po,
   input  logic [NVEC*NCHAIN*CHAIN_LEN-1:0] stim_flat,
   input  logic [NVEC*NCHAIN*CHAIN_LEN-1:0] exp_flat,
   input  logic [NVEC*NCHAIN*CHAIN_LEN-1:0] dc_flat,
   input  logic [NVEC*NPI-1:0]           pi_flat,
   input  logic [NVEC*NPO-1:0]           po_flat,
   output logic                          tc,
   output logic [NCHAIN-1:0]             si,
   output logic [NPI-1:0]                pi,
   output logic                          done,
   output logic [MISM_W-1:0]             mism
);
   localparam int NFF  = NCHAIN * CHAIN_LEN;
   localparam int SH_W = $clog2(CHAIN_LEN + 4);
   localparam int V_W  = $clog2(NVEC + 1);

   sq_state_e       st;
   logic [SH_W-1:0] sh;
   logic [V_W-1:0]  vi;
   int              hits;
   logic            launch;

   assign tc     = (st == SQ_FLUSH) || (st == SQ_LOAD) || (st == SQ_UNLOAD);
   assign done   = (st == SQ_DONE);
   assign launch = start && ((st == SQ_IDLE) || (st == SQ_DONE));

   always_comb begin
      int vb;
      int shi;
      vb  = int'(vi);
      shi = int'(sh);
      si  = '0;
      pi  = '0;
      for (int c = 0; c < NCHAIN; c++) begin
         if (st == SQ_FLUSH)
            si[c] = flush_bit(shi);
         else if (st == SQ_LOAD)
            si[c] = stim_flat[vb*NFF + c*CHAIN_LEN + CHAIN_LEN - 1 - shi];
      end
      if (st == SQ_CAPT)
         pi = pi_flat[vb*NPI +: NPI];
   end

   always_comb begin
      int vb;
      int shi;
      vb   = int'(vi);
      shi  = int'(sh);
      hits = 0;
      for (int c = 0; c < NCHAIN; c++) begin
         int   f;
         logic care;
         logic expb;
         f    = c*CHAIN_LEN + CHAIN_LEN - 1 - shi;
         care = 1'b0;
         expb = 1'b0;
         case (st)
            SQ_FLUSH: begin
               care = (shi >= CHAIN_LEN);
               expb = flush_bit(shi - CHAIN_LEN);
            end
            SQ_LOAD: begin
               if (vb == 0) begin
                  care = 1'b1;
                  expb = flush_bit(4 + shi);
               end else begin
                  care = !dc_flat[(vb-1)*NFF + f];
                  expb = exp_flat[(vb-1)*NFF + f];
               end
            end
            SQ_UNLOAD: begin
               care = !dc_flat[vb*NFF + f];
               expb = exp_flat[vb*NFF + f];
            end
            default: ;
         endcase
         if (care && (so[c] != expb)) hits = hits + 1;
      end
      if (st == SQ_CAPT)
         hits = hits + $countones(po ^ po_flat[vb*NPO +: NPO]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         sh   <= '0;
         vi   <= '0;
         mism <= '0;
      end else begin
         if (launch) mism <= '0;
         else        mism <= mism + MISM_W'(hits);
         case (st)
            SQ_IDLE, SQ_DONE: begin
               if (launch) begin
                  st <= SQ_FLUSH;
                  sh <= '0;
                  vi <= '0;
               end
            end
            SQ_FLUSH: begin
               if (sh == SH_W'(CHAIN_LEN + 3)) begin
                  st <= SQ_LOAD;
                  sh <= '0;
               end else sh <= sh + 1'b1;
            end
            SQ_LOAD: begin
               if (sh == SH_W'(CHAIN_LEN - 1)) begin
                  st <= SQ_CAPT;
                  sh <= '0;
               end else sh <= sh + 1'b1;
            end
            SQ_CAPT: begin
               if (vi == V_W'(NVEC - 1)) st <= SQ_UNLOAD;
               else begin
                  vi <= vi + 1'b1;
                  st <= SQ_LOAD;
               end
            end
            SQ_UNLOAD: begin
               if (sh == SH_W'(CHAIN_LEN - 1)) begin
                  st <= SQ_DONE;
                  sh <= '0;
               end else sh <= sh + 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assert_reset_idle_R1 : assert property (@(posedge clk)
      !rst_n |=> ((st == SQ_IDLE) && (mism == '0)));

   assert_single_capture_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_CAPT) |=> ((st == SQ_LOAD) || (st == SQ_UNLOAD)));

   assert_flush_full_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_LOAD) && ($past(st) == SQ_FLUSH)) |-> ($past(sh) == SH_W'(CHAIN_LEN + 3)));

   assert_mism_monotone_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      ((st != SQ_IDLE) && (st != SQ_DONE)) |=> (mism >= $past(mism)));
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
   parameter int NCHAIN    = 2,
   parameter int CHAIN_LEN = 4,
   parameter int NVEC      = 5,
   parameter int NPI       = 2,
   parameter int NPO       = 2,
   parameter int MISM_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              test_ctrl,
   output logic [NCHAIN-1:0] scan_out,
   output logic [NPO-1:0]    prim_out,
   output logic              done,
   output logic [MISM_W-1:0] mismatch_cnt
);
   localparam int NFF      = NCHAIN * CHAIN_LEN;
   localparam int MAX_CMP  = (CHAIN_LEN + 4) * NCHAIN + NVEC * (NFF + NPO);

   initial begin
      assert (CHAIN_LEN >= 2) else $error("CHAIN_LEN must be at least 2");
      assert (NVEC >= 1) else $error("NVEC must be at least 1");
      assert (NPI >= 1 && NPI <= NFF) else $error("NPI out of range");
      assert (NPO >= 1 && NPO <= NFF) else $error("NPO out of range");
      assert (MISM_W < 31 && (1 << MISM_W) > MAX_CMP) else $error("MISM_W too narrow");
   end

   logic [NCHAIN-1:0]   si;
   logic [NPI-1:0]      pi;
   logic [NVEC*NFF-1:0] stim_flat, exp_flat, dc_flat;
   logic [NVEC*NPI-1:0] pi_flat;
   logic [NVEC*NPO-1:0] po_flat;

   scan_vec_rom #(.NVEC(NVEC), .NFF(NFF), .NPI(NPI), .NPO(NPO)) u_rom (
      .stim_flat (stim_flat),
      .exp_flat  (exp_flat),
      .dc_flat   (dc_flat),
      .pi_flat   (pi_flat),
      .po_flat   (po_flat)
   );

   scan_seq_ctrl #(.NCHAIN(NCHAIN), .CHAIN_LEN(CHAIN_LEN), .NVEC(NVEC),
                   .NPI(NPI), .NPO(NPO), .MISM_W(MISM_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .so        (scan_out),
      .po        (prim_out),
      .stim_flat (stim_flat),
      .exp_flat  (exp_flat),
      .dc_flat   (dc_flat),
      .pi_flat   (pi_flat),
      .po_flat   (po_flat),
      .tc        (test_ctrl),
      .si        (si),
      .pi        (pi),
      .done      (done),
      .mism      (mismatch_cnt)
   );

   scan_cut #(.NCHAIN(NCHAIN), .CHAIN_LEN(CHAIN_LEN), .NPI(NPI), .NPO(NPO)) u_cut (
      .clk   (clk),
      .rst_n (rst_n),
      .tc    (test_ctrl),
      .si    (si),
      .pi    (pi),
      .so    (scan_out),
      .po    (prim_out)
   );

   assert_zero_fill_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (scan_out == '0));
endmodule

// File: tb/scan_test_seq_tb_top.sv
module scan_test_seq_tb_top;
   localparam int CLK_P  = 10;
   localparam int NCH    = 2;
   localparam int L      = 4;
   localparam int NV     = 5;
   localparam int NPI    = 2;
   localparam int NPO    = 2;
   localparam int MW     = 8;
   localparam int NFF    = NCH * L;
   localparam int TOTAL  = (NV + 2) * L + NV + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic test_ctrl, done;
   logic [NCH-1:0] scan_out;
   logic [NPO-1:0] prim_out;
   logic [MW-1:0]  mismatch_cnt;

   int checks = 0;
   int failures = 0;

   always #(CLK_P/2) clk = ~clk;

   scan_test_seq #(.NCHAIN(NCH), .CHAIN_LEN(L), .NVEC(NV), .NPI(NPI), .NPO(NPO),
                   .MISM_W(MW)) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .test_ctrl (test_ctrl),
      .scan_out (scan_out), .prim_out (prim_out), .done (done),
      .mismatch_cnt (mismatch_cnt)
   );

   function automatic int m_pat(int k);
      return (k >> 1) & 1;
   endfunction
   function automatic int m_stim(int v, int f);
      if (v == 0) return 0;
      if (v == 1) return 1;
      return (((3*f + 5*v) % 7) < 3) ? 1 : 0;
   endfunction
   function automatic int m_pi(int v, int j);
      return (((v + j) % 3) == 0) ? 1 : 0;
   endfunction
   function automatic int m_resp(int v, int f);
      return m_stim(v, (f + 1) % NFF) ^ (m_stim(v, f) & m_pi(v, f % NPI));
   endfunction
   function automatic int m_po(int v);
      int r = 0;
      for (int j = 0; j < NPO; j++) r |= (m_stim(v, j) ^ m_pi(v, j % NPI)) << j;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // step-by-step check of one run; abort_at >= 0 applies reset at that step
   task automatic run_seq(input int poke_at, input int abort_at);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < TOTAL; n++) begin
         if (n == abort_at) begin
            rst_n = 1'b0;
            @(negedge clk);
            chk(test_ctrl == 1'b0, "R1 mid-run reset test_ctrl", int'(test_ctrl), 0);
            chk(done == 1'b0, "R1 mid-run reset done", int'(done), 0);
            chk(mismatch_cnt == '0, "R1 mid-run reset count", int'(mismatch_cnt), 0);
            rst_n = 1'b1;
            @(negedge clk);
            chk(test_ctrl == 1'b0, "R1 idle after reset", int'(test_ctrl), 0);
            return;
         end
         start = (n == poke_at);
         chk(done == 1'b0, "R7 done low during run", int'(done), 0);
         if (n < L + 4) begin
            chk(test_ctrl == 1'b1, "R2 flush test_ctrl", int'(test_ctrl), 1);
            if (n >= L)
               for (int c = 0; c < NCH; c++)
                  chk(scan_out[c] == m_pat(n - L), "R2 R10 flush scan_out",
                      int'(scan_out[c]), m_pat(n - L));
         end else begin
            int m, v, r;
            m = n - (L + 4);
            v = m / (L + 1);
            r = m % (L + 1);
            if (v < NV && r == L) begin
               chk(test_ctrl == 1'b0, "R4 capture test_ctrl", int'(test_ctrl), 0);
               chk(int'(prim_out) == m_po(v), "R5 R4 prim_out at capture",
                   int'(prim_out), m_po(v));
            end else begin
               int j, vv;
               if (v < NV) begin j = r; vv = v - 1; end
               else begin j = m - NV * (L + 1); vv = NV - 1; end
               chk(test_ctrl == 1'b1, "R3 shift test_ctrl", int'(test_ctrl), 1);
               for (int c = 0; c < NCH; c++) begin
                  int e;
                  e = (vv < 0) ? m_pat(4 + j) : m_resp(vv, c*L + L - 1 - j);
                  chk(scan_out[c] == e[0], "R6 R5 R3 R10 scan_out stream",
                      int'(scan_out[c]), e);
               end
            end
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R7 done after exact length", int'(done), 1);
      chk(test_ctrl == 1'b0, "R7 test_ctrl low when done", int'(test_ctrl), 0);
      chk(mismatch_cnt == '0, "R9 mismatch count fault-free", int'(mismatch_cnt), 0);
      chk(scan_out == '0, "R8 zero fill after unload", int'(scan_out), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(done == 1'b1, "R7 done held", int'(done), 1);
         chk(scan_out == '0, "R8 outputs stay zero", int'(scan_out), 0);
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      failures++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      summary();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      chk(test_ctrl == 1'b0, "R1 reset test_ctrl", int'(test_ctrl), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(mismatch_cnt == '0, "R1 reset count", int'(mismatch_cnt), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(test_ctrl == 1'b0, "R1 idle test_ctrl", int'(test_ctrl), 0);
         chk(done == 1'b0, "R1 idle done", int'(done), 0);
      end
      run_seq(-1, -1);
      // R11: restart from done, with a stray start pulse mid-run
      run_seq(12, -1);
      // R1: reset in the middle of a run, then a clean run again
      run_seq(-1, 17);
      run_seq(-1, -1);
      summary();
   end
endmodule